// File: doc/BRIEF.md
# Hardware Return Address Stack

This block holds the return addresses of a small processor core. When the core takes a call, it raises a push request with the address to come back to. When it executes a return, it raises a pop request and receives the saved address on a registered output one clock later. The storage has 31 usable slots, each 21 bits wide, and is addressed by a 5-bit pointer. Pointer value zero means the stack is empty.

Two sticky flags record abnormal use. The full flag is raised when the stack fills or overflows. The underflow flag is raised when a return is taken on an empty stack. In that case the block hands back address zero, which sends the core to its reset vector. The pointer stays at zero and no other state changes.

A byte-wide register port lets software do the following:
- read the pointer and both flags;
- load the pointer;
- clear either flag;
- read or modify the top entry as three separate bytes.

Top module: `ret_addr_stack`

## Requirements
- R1: A synchronous reset leaves the pointer at 0 and both flags at 0, so the status register reads 00h. It also clears `pop_addr_o` and `reg_rdata_o`.
- R2: A push adds one to the pointer and stores `push_addr_i` at the new location. The top-of-stack bytes then return that address: select 1 gives bits 7:0, select 2 gives bits 15:8, and select 3 gives bits 20:16 zero-extended.
- R3: A pop with a nonzero pointer puts the entry at the pointer on `pop_addr_o` one cycle later and lowers the pointer by one. Entries come back in last-in, first-out order. Between pops, `pop_addr_o` holds its value.
- R4: A pop with the pointer at 0 drives 0 on `pop_addr_o`, sets the underflow flag and keeps the pointer at 0.
- R5: A push that brings the pointer to 31 sets the full flag. A push while the pointer is 31 keeps the pointer at 31, sets the full flag and overwrites entry 31.
- R6: Once set, each flag stays set through pushes and pops. It is cleared only by a status write with a 0 in its bit, or by reset. Writing a 1 to a flag bit has no effect.
- R7: The status register sits at select 0. Bit 7 is full, bit 6 is underflow, bit 5 reads 0, and bits 4:0 are the pointer. A status write loads the pointer from write data bits 4:0.
- R8: When a push sets the full flag in the same cycle that a status write clears it, the flag ends up set.
- R9: A write to a top-of-stack byte changes only that byte of the entry at the pointer, and the upper byte keeps only its low 5 bits. When the pointer is 0, these bytes read 0 and writes to them are dropped.
- R10: In a cycle that has a push, any pop, pointer write or top-of-stack byte write is dropped. In that case `pop_addr_o` keeps its previous value.
- R11: Register reads are registered. `reg_rdata_o` shows the register chosen by `reg_sel_i`, as it stood just before the clock edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Save a return address |
| push_addr_i | input | 21 | Return address to save |
| pop_i | input | 1 | Take back the top return address |
| pop_addr_o | output | 21 | Address handed back by the last pop (registered) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 status, 1 top low, 2 top high, 3 top upper |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data of the selected register |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a call-driven push and a software status write that clears the flags and reloads the pointer. The bench forces the two together while the pointer is at 30, so the push fills the stack. It then judges the status byte: the pointer must read 31 and the full flag must read set. The second pair is a push and a pop issued together. Here `pop_addr_o` must not change, and a later pop must return the address that was just pushed.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_TOS_LO = 2'd1,
    SEL_TOS_HI = 2'd2,
    SEL_TOS_UP = 2'd3
  } ras_sel_e;

  localparam int REG_W    = 8;
  localparam int FULL_BIT = 7;
  localparam int UNF_BIT  = 6;
endpackage

// File: rtl/ras_store.sv
module ras_store #(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [ADDR_W-1:0] rdata
);
  localparam int DEPTH = 1 << PTR_W;

  logic [ADDR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  input  logic              reg_wr_i,
  input  ras_sel_e          reg_sel,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic [ADDR_W-1:0] tos_raw_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              full_o,
  output logic              unf_o,
  output logic              mem_we_o,
  output logic [PTR_W-1:0]  mem_waddr_o,
  output logic [ADDR_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] pop_addr_o
);
  localparam int UP_W = ADDR_W - 16;
  localparam logic [PTR_W-1:0] PTR_MAX = '1;

  logic [PTR_W-1:0] ptr_q, ptr_d, push_ptr;
  logic             full_q, unf_q;
  logic             empty, do_pop, st_wr, tos_wr;
  logic             full_set, unf_set, full_keep, unf_keep;
  logic [ADDR_W-1:0] pop_q, merged;

  assign empty    = (ptr_q == '0);
  assign push_ptr = (ptr_q == PTR_MAX) ? ptr_q : ptr_q + 1'b1;
  assign do_pop   = pop_i && !push_i;
  assign st_wr    = reg_wr_i && (reg_sel == SEL_STATUS) && !push_i;
  assign tos_wr   = reg_wr_i && (reg_sel != SEL_STATUS) && !push_i && !empty;
  assign full_set = push_i && (push_ptr == PTR_MAX);
  assign unf_set  = do_pop && empty;
  assign full_keep = !(reg_wr_i && reg_sel == SEL_STATUS) || reg_wdata_i[FULL_BIT];
  assign unf_keep  = !(reg_wr_i && reg_sel == SEL_STATUS) || reg_wdata_i[UNF_BIT];

  always_comb begin
    merged = tos_raw_i;
    case (reg_sel)
      SEL_TOS_LO: merged[7:0]         = reg_wdata_i;
      SEL_TOS_HI: merged[15:8]        = reg_wdata_i;
      SEL_TOS_UP: merged[ADDR_W-1:16] = reg_wdata_i[UP_W-1:0];
      default:    merged              = tos_raw_i;
    endcase
  end

  always_comb begin
    ptr_d = ptr_q;
    if (push_i)           ptr_d = push_ptr;
    else if (do_pop)      ptr_d = empty ? ptr_q : ptr_q - 1'b1;
    else if (st_wr)       ptr_d = reg_wdata_i[PTR_W-1:0];
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_waddr_o = ptr_q;
    mem_wdata_o = merged;
    if (push_i) begin
      mem_we_o    = 1'b1;
      mem_waddr_o = push_ptr;
      mem_wdata_o = push_addr_i;
    end else if (tos_wr) begin
      mem_we_o    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
      unf_q  <= 1'b0;
      pop_q  <= '0;
    end else begin
      ptr_q  <= ptr_d;
      full_q <= (full_q && full_keep) || full_set;
      unf_q  <= (unf_q && unf_keep) || unf_set;
      if (do_pop) pop_q <= empty ? '0 : tos_raw_i;
    end
  end

  assign ptr_o      = ptr_q;
  assign full_o     = full_q;
  assign unf_o      = unf_q;
  assign pop_addr_o = pop_q;

  // R2
  push_inc_chk: assert property (@(posedge clk) disable iff (rst)
    push_i && ptr_q != PTR_MAX |=> ptr_q == $past(ptr_q) + 1'b1);
  // R3
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    pop_i && !push_i && ptr_q != '0 |=> ptr_q == $past(ptr_q) - 1'b1);
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    pop_i && !push_i && ptr_q == '0 |=> unf_q && ptr_q == '0 && pop_addr_o == '0);
  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    push_i && ptr_q == PTR_MAX |=> full_q && ptr_q == PTR_MAX);
  // R6
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    unf_q && !(reg_wr_i && reg_sel == SEL_STATUS && !reg_wdata_i[UNF_BIT]) |=> unf_q);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    push_i && ptr_q >= PTR_MAX - 1'b1 |=> full_q);
  // R10
  pop_drop_chk: assert property (@(posedge clk) disable iff (rst)
    push_i && pop_i |=> $stable(pop_addr_o));
endmodule

// File: rtl/ras_regs.sv
module ras_regs
  import ras_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  ras_sel_e          reg_sel,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              full_i,
  input  logic              unf_i,
  input  logic [ADDR_W-1:0] tos_raw_i,
  output logic [REG_W-1:0]  rdata_o
);
  logic [ADDR_W-1:0] tos;
  logic [REG_W-1:0]  status, upper, rd_d;

  assign tos = (ptr_i == '0) ? '0 : tos_raw_i;

  always_comb begin
    status = '0;
    status[FULL_BIT]   = full_i;
    status[UNF_BIT]    = unf_i;
    status[PTR_W-1:0]  = ptr_i;
    upper = '0;
    upper[ADDR_W-17:0] = tos[ADDR_W-1:16];
  end

  always_comb begin
    case (reg_sel)
      SEL_TOS_LO: rd_d = tos[7:0];
      SEL_TOS_HI: rd_d = tos[15:8];
      SEL_TOS_UP: rd_d = upper;
      default:    rd_d = status;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_d;
  end

  // R7
  status_gap_chk: assert property (@(posedge clk) disable iff (rst)
    reg_sel == SEL_STATUS |=> rdata_o[5] == 1'b0);
  // R9
  empty_tos_chk: assert property (@(posedge clk) disable iff (rst)
    reg_sel != SEL_STATUS && ptr_i == '0 |=> rdata_o == '0);
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pop_addr_o,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o
);
  ras_sel_e          sel;
  logic [PTR_W-1:0]  ptr, waddr;
  logic              full, unf, we;
  logic [ADDR_W-1:0] tos_raw, wdata;

  assign sel = ras_sel_e'(reg_sel_i);

  ras_ctrl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst(rst), .push_i(push_i), .push_addr_i(push_addr_i),
    .pop_i(pop_i), .reg_wr_i(reg_wr_i), .reg_sel(sel),
    .reg_wdata_i(reg_wdata_i), .tos_raw_i(tos_raw), .ptr_o(ptr),
    .full_o(full), .unf_o(unf), .mem_we_o(we), .mem_waddr_o(waddr),
    .mem_wdata_o(wdata), .pop_addr_o(pop_addr_o)
  );

  ras_store #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ptr), .rdata(tos_raw)
  );

  ras_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_sel(sel), .ptr_i(ptr), .full_i(full),
    .unf_i(unf), .tos_raw_i(tos_raw), .rdata_o(reg_rdata_o)
  );
endmodule

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // vector: {op(0 push,1 pop), data, expected pop address, expected pointer}
  localparam logic [48:0] VEC [NV] = '{
    {2'd0, 21'h001A34, 21'h000000, 5'd1},
    {2'd0, 21'h000D58, 21'h000000, 5'd2},
    {2'd1, 21'h000000, 21'h000D58, 5'd1},
    {2'd0, 21'h1FFFFF, 21'h000000, 5'd2},
    {2'd1, 21'h000000, 21'h1FFFFF, 5'd1},
    {2'd1, 21'h000000, 21'h001A34, 5'd0},
    {2'd1, 21'h000000, 21'h000000, 5'd0},
    {2'd0, 21'h0ABCDE, 21'h000000, 5'd1}
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        push_i = 1'b0, pop_i = 1'b0, reg_wr_i = 1'b0;
  logic [20:0] push_addr_i = '0;
  logic [1:0]  reg_sel_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [20:0] pop_addr_o;
  logic [7:0]  reg_rdata_o;
  int          checks = 0, fails = 0, cycles = 0;
  logic [48:0] v;
  logic [7:0]  rd;
  logic [20:0] prev;

  ret_addr_stack i_ret_addr_stack (
    .clk(clk), .rst(rst), .push_i(push_i), .push_addr_i(push_addr_i),
    .pop_i(pop_i), .pop_addr_o(pop_addr_o), .reg_wr_i(reg_wr_i),
    .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      report();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    push_i = 0; pop_i = 0; reg_wr_i = 0;
  endtask

  task automatic do_push(logic [20:0] a);
    push_i = 1; push_addr_i = a; step();
  endtask

  task automatic do_pop();
    pop_i = 1; step();
  endtask

  task automatic wr_reg(logic [1:0] s, logic [7:0] d);
    reg_wr_i = 1; reg_sel_i = s; reg_wdata_i = d; step();
  endtask

  task automatic rd_reg(logic [1:0] s, output logic [7:0] d);
    reg_sel_i = s; step(); d = reg_rdata_o;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 pop_addr", 32'(pop_addr_o), 0);
    chk("R1 rdata", 32'(reg_rdata_o), 0);
    rd_reg(0, rd); chk("R1 status", 32'(rd), 0);

    // R2 R3 R4 vector walk
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (v[48:47] == 2'd0) do_push(v[46:26]);
      else begin
        do_pop();
        chk("R3 R4 pop address", 32'(pop_addr_o), 32'(v[25:5]));
      end
      rd_reg(0, rd);
      chk("R2 R3 pointer", 32'(rd[4:0]), 32'(v[4:0]));
    end
    rd_reg(0, rd); chk("R4 underflow flag", 32'(rd), 32'h41);
    // R6 write 1 to full bit, 0 to underflow bit
    wr_reg(0, 8'h81);
    rd_reg(0, rd); chk("R6 clear", 32'(rd), 32'h01);

    // R2 top bytes
    rd_reg(1, rd); chk("R2 tos low", 32'(rd), 32'hDE);
    rd_reg(2, rd); chk("R2 tos high", 32'(rd), 32'hBC);
    rd_reg(3, rd); chk("R2 tos upper", 32'(rd), 32'h0A);
    // R9 byte writes
    wr_reg(1, 8'h11); wr_reg(2, 8'h22); wr_reg(3, 8'hFF);
    rd_reg(3, rd); chk("R9 upper masked", 32'(rd), 32'h1F);
    rd_reg(1, rd); chk("R9 low written", 32'(rd), 32'h11);
    do_pop(); chk("R9 merged entry", 32'(pop_addr_o), 32'h1F2211);
    wr_reg(1, 8'h55);
    rd_reg(1, rd); chk("R9 empty tos", 32'(rd), 0);
    rd_reg(0, rd); chk("R9 pointer kept", 32'(rd), 0);

    // R5 fill
    for (int i = 1; i <= 30; i++) do_push(21'(i));
    rd_reg(0, rd); chk("R5 not yet full", 32'(rd), 32'h1E);
    do_push(21'd31);
    rd_reg(0, rd); chk("R5 full at 31", 32'(rd), 32'h9F);
    do_push(21'h155555);
    rd_reg(0, rd); chk("R5 pointer pinned", 32'(rd), 32'h9F);
    do_pop(); chk("R5 overwrite", 32'(pop_addr_o), 32'h155555);
    do_pop(); chk("R3 lifo", 32'(pop_addr_o), 30);
    rd_reg(0, rd); chk("R6 full sticky", 32'(rd), 32'h9D);

    // R7 R8 R10 push with status clear
    wr_reg(0, 8'h1E);
    rd_reg(0, rd); chk("R7 pointer write", 32'(rd), 32'h1E);
    push_i = 1; push_addr_i = 21'h0F0F0F;
    reg_wr_i = 1; reg_sel_i = 0; reg_wdata_i = 8'h00; step();
    rd_reg(0, rd); chk("R8 set wins", 32'(rd), 32'h9F);

    // R10 push with pop
    wr_reg(0, 8'h03);
    rd_reg(0, rd); chk("R7 status", 32'(rd), 32'h03);
    prev = pop_addr_o;
    push_i = 1; push_addr_i = 21'h012345; pop_i = 1; step();
    chk("R10 pop dropped", 32'(pop_addr_o), 32'(prev));
    rd_reg(0, rd); chk("R10 pointer", 32'(rd), 32'h04);
    do_pop(); chk("R10 pushed entry", 32'(pop_addr_o), 32'h012345);

    // R11 registered read
    reg_sel_i = 0; do_push(21'h000777);
    chk("R11 pre-edge value", 32'(reg_rdata_o), 32'h03);

    // R1 reset mid-run
    rst = 1; step(); rst = 0;
    rd_reg(0, rd); chk("R1 reset status", 32'(rd), 0);
    chk("R1 reset pop", 32'(pop_addr_o), 0);
    report();
  end
endmodule